// File: doc/BRIEF.md
# DMA Register Window Sequencer

This block lets a DMA engine that sees only one data-port register reach a run of consecutive peripheral registers. Configuration inputs give a word-granular base address, an access count and a request source select. When the selected event arrives, the block loads an internal byte pointer, arms a window of count+1 accesses and raises a DMA request.

Each read or write the DMA makes to the data port is forwarded, in the same cycle, as a strobe to the register at the current pointer. The pointer then moves on by one word. Once the window is used up, further data-port accesses are dropped. The block produces only the redirected address, strobes and data paths; the target registers live outside it.

Top module: `dwin_sequencer`

## Requirements
- R1: After reset the request output is low, no register strobe is given, and a data-port read returns 0.
- R2: With a source select of 0, no event raises the request or opens a window.
- R3: A select value k (1 to NUM_EVT) picks event bit k-1. That bit, high at a clock edge, opens the window and raises the request in the following cycle. Other event bits have no effect.
- R4: The first access of a window is forwarded to byte address base*4, which is the base field with two zero bits appended.
- R5: Each forwarded access moves the pointer up by 4 for the next access.
- R6: A window allows exactly count+1 accesses. After that, writes produce no write strobe and reads produce no read strobe and return 0.
- R7: The request stays high until the first data-port access of the window and is low from the next cycle on.
- R8: A selected event during an open window reloads the pointer from the base field and restarts the count.
- R9: During a window, read data from the target register is returned on the data port and write data is passed through unchanged.
- R10: The 9-bit byte pointer wraps modulo 512 when it steps past 508.
- R11: When read and write are requested in the same cycle, only the write is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 7 | Word address of the first target register |
| cfg_count_i | input | 4 | Number of accesses minus one |
| cfg_sel_i | input | 3 | Request source select, 0 disables requests |
| evt_i | input | 7 | Event vector, one bit per request source |
| port_rd_i | input | 1 | Read of the data-port register |
| port_wr_i | input | 1 | Write of the data-port register |
| port_wdata_i | input | 32 | Write data on the data port |
| port_rdata_o | output | 32 | Read data returned on the data port |
| reg_addr_o | output | 9 | Byte address of the target register |
| reg_rd_o | output | 1 | Read strobe to the target register |
| reg_wr_o | output | 1 | Write strobe to the target register |
| reg_wdata_o | output | 32 | Write data to the target register |
| reg_rdata_i | input | 32 | Read data from the target register |
| dma_req_o | output | 1 | DMA request |

## Verification
Bursts of mixed reads and writes walk the window from different bases and counts. A count of 0 and a one-past-the-end access separate a correct limit from an off-by-one limit. Events on unselected bits and a zero select show whether the source decode is exact. A second event in mid-burst tells a reload apart from a pointer that merely continues. A window starting at the top word shows the pointer wrap, and a combined read/write cycle exposes the strobe priority.

// File: rtl/dwin_pkg.sv
`timescale 1ns/1ps
package dwin_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/dwin_trigger.sv
`timescale 1ns/1ps
module dwin_trigger #(
  parameter int unsigned NUM_EVT = 7,
  parameter int unsigned SEL_W   = $clog2(NUM_EVT + 1)
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  logic [NUM_EVT-1:0] match;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_src
    assign match[g] = evt_i[g] && (sel_i == SEL_W'(g + 1));
  end

  assign hit_o = |match;
endmodule

// File: rtl/dwin_access_decode.sv
`timescale 1ns/1ps
module dwin_access_decode
  import dwin_pkg::*;
(
  input  logic rd_i,
  input  logic wr_i,
  output acc_e kind_o
);
  // write takes priority on a combined request
  always_comb begin
    if (wr_i)      kind_o = ACC_WRITE;
    else if (rd_i) kind_o = ACC_READ;
    else           kind_o = ACC_NONE;
  end
endmodule

// File: rtl/dwin_pointer.sv
`timescale 1ns/1ps
module dwin_pointer
  import dwin_pkg::*;
#(
  parameter int unsigned BASE_W = 7,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned ADDR_W = BASE_W + WORD_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              active_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << WORD_SHIFT);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o    <= '0;
      left_q   <= '0;
      active_o <= 1'b0;
    end else if (load_i) begin
      ptr_o    <= {base_i, {WORD_SHIFT{1'b0}}};
      left_q   <= count_i;
      active_o <= 1'b1;
    end else if (step_i && active_o) begin
      if (left_q == '0) begin
        active_o <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        ptr_o  <= ptr_o + STEP;
      end
    end
  end
endmodule

// File: rtl/dwin_sequencer.sv
`timescale 1ns/1ps
module dwin_sequencer
  import dwin_pkg::*;
#(
  parameter int unsigned NUM_EVT = 7,
  parameter int unsigned BASE_W  = 7,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SEL_W  = $clog2(NUM_EVT + 1),
  localparam int unsigned ADDR_W = BASE_W + WORD_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              port_rd_i,
  input  logic              port_wr_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  output logic [DATA_W-1:0] port_rdata_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              dma_req_o
);
  logic hit;
  acc_e kind;
  logic active;
  logic access;

  dwin_trigger #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_trig (
    .sel_i (cfg_sel_i),
    .evt_i (evt_i),
    .hit_o (hit)
  );

  dwin_access_decode u_dec (
    .rd_i   (port_rd_i),
    .wr_i   (port_wr_i),
    .kind_o (kind)
  );

  assign access = (kind != ACC_NONE);

  dwin_pointer #(.BASE_W(BASE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (hit),
    .base_i   (cfg_base_i),
    .count_i  (cfg_count_i),
    .step_i   (access),
    .ptr_o    (reg_addr_o),
    .active_o (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dma_req_o <= 1'b0;
    else if (hit)               dma_req_o <= 1'b1;
    else if (access && active)  dma_req_o <= 1'b0;
  end

  assign reg_wr_o     = active && (kind == ACC_WRITE);
  assign reg_rd_o     = active && (kind == ACC_READ);
  assign reg_wdata_o  = port_wdata_i;
  assign port_rdata_o = reg_rd_o ? reg_rdata_i : '0;
endmodule

// File: rtl/dwin_sequencer_chk.sv
`timescale 1ns/1ps
module dwin_sequencer_chk #(
  parameter int unsigned NUM_EVT = 7,
  parameter int unsigned BASE_W  = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned ADDR_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BASE_W-1:0] cfg_base_i,
  input logic [SEL_W-1:0]  cfg_sel_i,
  input logic [NUM_EVT-1:0] evt_i,
  input logic              port_rd_i,
  input logic              port_wr_i,
  input logic [DATA_W-1:0] port_rdata_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic              dma_req_o
);
  logic hit_c;
  always_comb begin
    hit_c = 1'b0;
    for (int i = 0; i < NUM_EVT; i++)
      if (int'(cfg_sel_i) == i + 1 && evt_i[i]) hit_c = 1'b1;
  end

  a_r3_req_from_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> $past(hit_c));

  a_r4_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c |=> (reg_addr_o == {$past(cfg_base_i), 2'b00}));

  a_r5_step_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_rd_o || reg_wr_o) && !hit_c) |=>
      ((reg_rd_o || reg_wr_o) -> (reg_addr_o == ADDR_W'($past(reg_addr_o) + 4))));

  a_r6_no_stray_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_rd_i && !port_wr_i) |-> (!reg_rd_o && !reg_wr_o));

  a_r6_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_i && !reg_rd_o) |-> (port_rdata_o == '0));

  a_r7_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && (reg_rd_o || reg_wr_o) && !hit_c) |=> !dma_req_o);

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_i && port_wr_i) |-> !reg_rd_o);
endmodule

bind dwin_sequencer dwin_sequencer_chk #(
  .NUM_EVT(NUM_EVT), .BASE_W(BASE_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_base_i   (cfg_base_i),
  .cfg_sel_i    (cfg_sel_i),
  .evt_i        (evt_i),
  .port_rd_i    (port_rd_i),
  .port_wr_i    (port_wr_i),
  .port_rdata_o (port_rdata_o),
  .reg_addr_o   (reg_addr_o),
  .reg_rd_o     (reg_rd_o),
  .reg_wr_o     (reg_wr_o),
  .dma_req_o    (dma_req_o)
);

// File: tb/tb_dwin_sequencer.sv
`timescale 1ns/1ps
module tb_dwin_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  base = '0;
  logic [3:0]  count = '0;
  logic [2:0]  sel = '0;
  logic [6:0]  evt = '0;
  logic        prd = 1'b0;
  logic        pwr = 1'b0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [8:0]  raddr;
  logic        rrd, rwr;
  logic [31:0] rwdata;
  logic [31:0] rrdata;
  logic        req;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign rrdata = 32'hA500_0000 | {23'h0, raddr};

  dwin_sequencer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_base_i(base), .cfg_count_i(count), .cfg_sel_i(sel), .evt_i(evt),
    .port_rd_i(prd), .port_wr_i(pwr), .port_wdata_i(pwdata), .port_rdata_o(prdata),
    .reg_addr_o(raddr), .reg_rd_o(rrd), .reg_wr_o(rwr), .reg_wdata_o(rwdata),
    .reg_rdata_i(rrdata), .dma_req_o(req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fire(input int k);
    @(negedge clk);
    evt = 7'(1 << k);
    @(negedge clk);
    evt = '0;
  endtask

  // one data-port access; checks forwarding at mid-cycle
  task automatic access(input bit wr, input bit ok, input logic [8:0] addr,
                        input string tag);
    @(negedge clk);
    pwr = wr;
    prd = !wr;
    pwdata = 32'h1234_0000 | {23'h0, addr};
    #1;
    if (ok) begin
      check(wr ? rwr : rrd, {tag, " strobe"}, {31'h0, wr ? rwr : rrd}, 32'h1);
      check(raddr == addr, {tag, " addr"}, {23'h0, raddr}, {23'h0, addr});
      if (wr) check(rwdata == pwdata, {tag, " R9 wdata"}, rwdata, pwdata);
      else check(prdata == (32'hA500_0000 | {23'h0, addr}), {tag, " R9 rdata"},
                 prdata, 32'hA500_0000 | {23'h0, addr});
    end else begin
      check(!rwr && !rrd, {tag, " no strobe"}, {30'h0, rwr, rrd}, 32'h0);
      if (!wr) check(prdata == '0, {tag, " zero read"}, prdata, 32'h0);
    end
    @(posedge clk);
    @(negedge clk);
    prd = 1'b0;
    pwr = 1'b0;
  endtask

  task automatic t_reset();
    check(req == 1'b0, "R1 req after reset", {31'h0, req}, 32'h0);
    access(1'b0, 1'b0, 9'h0, "R1 read");
    access(1'b1, 1'b0, 9'h0, "R1 write");
  endtask

  task automatic t_disabled();
    sel = 3'd0; base = 7'd3; count = 4'd1;
    for (int k = 0; k < 7; k++) fire(k);
    check(req == 1'b0, "R2 req with sel 0", {31'h0, req}, 32'h0);
    access(1'b0, 1'b0, 9'h0, "R2 read");
  endtask

  task automatic t_select();
    sel = 3'd3; base = 7'd2; count = 4'd0;
    fire(0); fire(6);
    check(req == 1'b0, "R3 unselected bits", {31'h0, req}, 32'h0);
    access(1'b1, 1'b0, 9'h0, "R3 no window");
    fire(2);
    check(req == 1'b1, "R3 selected bit", {31'h0, req}, 32'h1);
    access(1'b1, 1'b1, 9'd8, "R6 count0 only access");
    access(1'b1, 1'b0, 9'd8, "R6 count0 past end");
  endtask

  task automatic t_burst();
    sel = 3'd5; base = 7'd5; count = 4'd2;
    fire(4);
    check(req == 1'b1, "R7 req held", {31'h0, req}, 32'h1);
    @(negedge clk);
    check(req == 1'b1, "R7 req still held", {31'h0, req}, 32'h1);
    access(1'b1, 1'b1, 9'd20, "R4 first");
    check(req == 1'b0, "R7 req dropped", {31'h0, req}, 32'h0);
    access(1'b0, 1'b1, 9'd24, "R5 second");
    access(1'b1, 1'b1, 9'd28, "R5 third");
    access(1'b1, 1'b0, 9'd28, "R6 write past end");
    access(1'b0, 1'b0, 9'd28, "R6 read past end");
  endtask

  task automatic t_reload();
    sel = 3'd1; base = 7'd10; count = 4'd3;
    fire(0);
    access(1'b0, 1'b1, 9'd40, "R8 pre a");
    access(1'b0, 1'b1, 9'd44, "R8 pre b");
    base = 7'd16;
    fire(0);
    check(req == 1'b1, "R8 req again", {31'h0, req}, 32'h1);
    for (int i = 0; i < 4; i++) access(1'b1, 1'b1, 9'(64 + 4 * i), "R8 reloaded");
    access(1'b0, 1'b0, 9'd76, "R8 count restarted");
  endtask

  task automatic t_wrap();
    sel = 3'd7; base = 7'd127; count = 4'd1;
    fire(6);
    access(1'b0, 1'b1, 9'd508, "R10 top");
    access(1'b0, 1'b1, 9'd0, "R10 wrapped");
  endtask

  task automatic t_both();
    sel = 3'd2; base = 7'd1; count = 4'd1;
    fire(1);
    @(negedge clk);
    prd = 1'b1; pwr = 1'b1;
    #1;
    check(rwr && !rrd, "R11 write wins", {30'h0, rwr, rrd}, 32'h2);
    @(negedge clk);
    prd = 1'b0; pwr = 1'b0;
    access(1'b0, 1'b1, 9'd8, "R11 counted once");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_select();
    t_burst();
    t_reload();
    t_wrap();
    t_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule